// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host port and an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. The host issues one request at a time with a simple valid/ready handshake. The block produces the RAM address, a pair of chip selects of opposite polarity, a write strobe, an output enable, one active-low enable per byte lane, and the data-bus drive value with its output-enable. It also captures read data and returns it with a single-cycle valid pulse.

Every phase of an access is a whole number of clock cycles, set by parameters. At elaboration the block compares each phase total against the RAM's minimum times, given in picoseconds, and refuses a setting that breaks one. After reset the host port stays closed for a power-up interval counted in clock cycles (about 1 ms at the target clock). Writes always finish on the rising edge of the write strobe. Data, address, selection and lanes stay put for a hold phase after that edge. A build option keeps the output enable low at the start of a write. The block then waits out the RAM's output turn-off time after the write strobe falls, and only then drives the bus.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset is released, `ready` stays low and the RAM stays deselected for exactly PWRUP_CYC clock edges. `ready` is first high after edge PWRUP_CYC.
- R2: The RAM is selected only while `ram_ce1_n` is 0 and `ram_ce2` is 1. The two lines always move together, and both sit at their inactive levels (1 and 0) whenever the block is idle.
- R3: A read holds the output enable low, with lanes enabled per `be`, for T_RD cycles after T_SETUP cycles of address setup. `rvalid` pulses for one cycle exactly T_SETUP+T_RD edges after the accepting edge. `rdata` bits [7:0] follow `be[0]` and bits [15:8] follow `be[1]`; a lane whose bit is 0 reads as zero.
- R4: A write ends on the rising edge of `ram_we_n`. The data bus stays driven, and address, selection and lane enables stay unchanged, for T_HOLD cycles after that edge.
- R5: Only the lanes whose `be` bit is 1 are written (`ram_lane_n[i]` = 0). A write request with `be` = 00 completes with both lanes inactive and leaves the RAM contents unchanged.
- R6: After any read, the output enable is high for at least T_TURN ≥ 1 cycles before the block drives the data bus. The block never drives the bus while the RAM may be driving it.
- R7: With WRITE_OE_LOW = 1, the output enable is low when the write strobe falls, and the block does not drive the bus during the first T_OFF cycles of the write strobe's low time.
- R8: A request is taken only on an edge where `req` and `ready` are both high. `ready` then stays low for T_SETUP+T_RD+T_TURN cycles for a read, or T_SETUP+T_OFF+T_WDRV+T_HOLD cycles for a write (the T_OFF term only when WRITE_OE_LOW = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Host word address |
| wdata | input | 8*LANES | Write data |
| be | input | LANES | Lane select, bit i covers bits [8i+7:8i] |
| ready | output | 1 | Block can accept a request |
| rdata | output | 8*LANES | Captured read data, unselected lanes zero |
| rvalid | output | 1 | One-cycle read data valid |
| ram_addr | output | AW | RAM address |
| ram_ce1_n | output | 1 | Active-low chip select |
| ram_ce2 | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_lane_n | output | LANES | Byte lane enables, active low |
| ram_dq_o | output | 8*LANES | Data to drive onto the RAM bus |
| ram_dq_oe | output | 1 | Drive enable for the RAM bus |
| ram_dq_i | input | 8*LANES | Data sampled from the RAM bus |

## Verification
Each host transaction is timed from its accepting edge. `rvalid` is due at edge T_SETUP+T_RD, and `ready` returns at the read or write totals of R8. The bench counts edges from the accepting edge and compares every count with these sums. All outputs are sampled on the falling clock edge, half a cycle after the registers settle. The lockout is checked one edge before and at edge PWRUP_CYC. A behavioural RAM model watches the strobes on every falling edge and counts breaches of the selection, contention, turn-off, pulse-width and termination rules. Read-back data is compared with a shadow memory updated only for the lanes each write enabled.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_RACC,
      ST_TURN,
      ST_WOFF,
      ST_WDRV,
      ST_WHOLD
   } sram_st_e;

   typedef struct packed {
      logic sel;
      logic wr_low;
      logic rd_en;
      logic lanes_on;
      logic drive;
   } strobe_t;

   // strobe levels belonging to each state; oe_low_wr selects the write variant
   function automatic strobe_t decode_state(sram_st_e st, logic is_wr, logic oe_low_wr);
      strobe_t s;
      s.sel      = (st != ST_IDLE) && (st != ST_TURN);
      s.wr_low   = (st == ST_WOFF) || (st == ST_WDRV);
      s.rd_en    = (st == ST_RACC) ||
                   (oe_low_wr && is_wr && ((st == ST_SETUP) || (st == ST_WOFF)));
      s.lanes_on = s.sel;
      s.drive    = (st == ST_WDRV) || (st == ST_WHOLD);
      return s;
   endfunction

endpackage

// File: rtl/sram_pwrup_gate.sv
`timescale 1ns/100ps
module sram_pwrup_gate #(
   parameter int PWRUP_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic pwr_ok
);
   generate
      if (PWRUP_CYC == 0) begin : g_none
         assign pwr_ok = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(PWRUP_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(PWRUP_CYC - 1);
         logic [CW-1:0] cnt;
         logic          ok_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               ok_q <= 1'b0;
            end else if (!ok_q) begin
               cnt  <= cnt + 1'b1;
               ok_q <= (cnt == LAST);
            end
         end
         assign pwr_ok = ok_q;
      end
   endgenerate
endmodule

// File: rtl/sram_phase_timer.sv
`timescale 1ns/100ps
module sram_phase_timer #(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PH_W-1:0] len,
   output logic            expire
);
   logic [PH_W-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= len - 1'b1;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end
   assign expire = (cnt == '0);
endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/100ps
module sram_dq_path #(
   parameter int LANES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic [LANES-1:0]     lane_en,
   input  logic [8*LANES-1:0]   dq_i,
   output logic [8*LANES-1:0]   rdata,
   output logic                 rvalid
);
   logic [8*LANES-1:0] masked;
   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         assign masked[8*gi +: 8] = lane_en[gi] ? dq_i[8*gi +: 8] : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= capture;
         if (capture) rdata <= masked;
      end
   end
endmodule

// File: rtl/sram_timing_ctrl.sv
`timescale 1ns/100ps
module sram_timing_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int AW           = 18,
   parameter int LANES        = 2,
   parameter int PWRUP_CYC    = 100000,
   parameter int CLK_PS       = 10000,
   parameter int T_SETUP      = 1,
   parameter int T_RD         = 2,
   parameter int T_TURN       = 1,
   parameter int T_OFF        = 1,
   parameter int T_WDRV       = 1,
   parameter int T_HOLD       = 1,
   parameter bit WRITE_OE_LOW = 1'b0,
   parameter int MIN_RC_PS    = 10000,
   parameter int MAX_AA_PS    = 10000,
   parameter int MAX_DOE_PS   = 5000,
   parameter int MIN_WC_PS    = 10000,
   parameter int MIN_SCE_PS   = 7000,
   parameter int MAX_HZ_PS    = 5000,
   parameter int PH_W         = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 we,
   input  logic [AW-1:0]        addr,
   input  logic [8*LANES-1:0]   wdata,
   input  logic [LANES-1:0]     be,
   output logic                 ready,
   output logic [8*LANES-1:0]   rdata,
   output logic                 rvalid,
   output logic [AW-1:0]        ram_addr,
   output logic                 ram_ce1_n,
   output logic                 ram_ce2,
   output logic                 ram_we_n,
   output logic                 ram_oe_n,
   output logic [LANES-1:0]     ram_lane_n,
   output logic [8*LANES-1:0]   ram_dq_o,
   output logic                 ram_dq_oe,
   input  logic [8*LANES-1:0]   ram_dq_i
);
   localparam int WOFF_CYC  = WRITE_OE_LOW ? T_OFF : 0;
   localparam int RD_TOTAL  = T_SETUP + T_RD + T_TURN;
   localparam int WR_TOTAL  = T_SETUP + WOFF_CYC + T_WDRV + T_HOLD;
   localparam int WR_END    = T_SETUP + WOFF_CYC + T_WDRV;
   localparam int PH_MAX    = (1 << PH_W) - 1;
   localparam logic [PH_W-1:0] L_SET  = PH_W'(T_SETUP);
   localparam logic [PH_W-1:0] L_RD   = PH_W'(T_RD);
   localparam logic [PH_W-1:0] L_TURN = PH_W'(T_TURN);
   localparam logic [PH_W-1:0] L_OFF  = PH_W'(T_OFF);
   localparam logic [PH_W-1:0] L_WDRV = PH_W'(T_WDRV);
   localparam logic [PH_W-1:0] L_HOLD = PH_W'(T_HOLD);

   // elaboration-time checks of the parameter set against the RAM minimums
   generate
      if (AW < 1 || LANES < 1)
         begin : g_bad_shape   $error("sram_timing_ctrl: AW and LANES must be at least 1"); end
      if (T_SETUP < 1 || T_RD < 1 || T_TURN < 1 || T_WDRV < 1 || T_HOLD < 1 || T_OFF < 1)
         begin : g_bad_len     $error("sram_timing_ctrl: every phase needs at least one cycle"); end
      if (T_SETUP > PH_MAX || T_RD > PH_MAX || T_TURN > PH_MAX ||
          T_OFF > PH_MAX || T_WDRV > PH_MAX || T_HOLD > PH_MAX)
         begin : g_bad_width   $error("sram_timing_ctrl: a phase does not fit PH_W bits"); end
      if ((T_SETUP + T_RD) * CLK_PS < MAX_AA_PS)
         begin : g_bad_aa      $error("sram_timing_ctrl: address-to-data time not covered"); end
      if (T_RD * CLK_PS < MAX_DOE_PS)
         begin : g_bad_doe     $error("sram_timing_ctrl: output-enable-to-data time not covered"); end
      if (RD_TOTAL * CLK_PS < MIN_RC_PS)
         begin : g_bad_rc      $error("sram_timing_ctrl: read cycle too short"); end
      if (WR_TOTAL * CLK_PS < MIN_WC_PS)
         begin : g_bad_wc      $error("sram_timing_ctrl: write cycle too short"); end
      if (WR_END * CLK_PS < MIN_SCE_PS)
         begin : g_bad_sce     $error("sram_timing_ctrl: select-to-write-end too short"); end
      if (WRITE_OE_LOW && (T_OFF * CLK_PS < MAX_HZ_PS))
         begin : g_bad_hz      $error("sram_timing_ctrl: output turn-off wait too short"); end
   endgenerate

   sram_st_e state, nxt;
   logic     pwr_ok, expire, load, capture, accept;
   logic [PH_W-1:0] len;

   logic              op_we;
   logic [LANES-1:0]  op_be;
   logic              cur_we;
   logic [LANES-1:0]  cur_be;
   strobe_t           stb_d;

   sram_pwrup_gate #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok)
   );

   sram_phase_timer #(.PH_W(PH_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .len(len), .expire(expire)
   );

   sram_dq_path #(.LANES(LANES)) u_dq (
      .clk(clk), .rst_n(rst_n), .capture(capture), .lane_en(op_be),
      .dq_i(ram_dq_i), .rdata(rdata), .rvalid(rvalid)
   );

   assign ready  = pwr_ok && (state == ST_IDLE);
   assign accept = req && ready;
   assign cur_we = accept ? we : op_we;
   assign cur_be = accept ? be : op_be;

   // next-state and phase-length selection
   always_comb begin
      nxt     = state;
      load    = 1'b0;
      len     = L_SET;
      capture = 1'b0;
      unique case (state)
         ST_IDLE: if (accept) begin
            nxt  = ST_SETUP;
            load = 1'b1;
            len  = L_SET;
         end
         ST_SETUP: if (expire) begin
            load = 1'b1;
            if (!op_we) begin
               nxt = ST_RACC;
               len = L_RD;
            end else if (WOFF_CYC > 0) begin
               nxt = ST_WOFF;
               len = L_OFF;
            end else begin
               nxt = ST_WDRV;
               len = L_WDRV;
            end
         end
         ST_RACC: if (expire) begin
            nxt     = ST_TURN;
            load    = 1'b1;
            len     = L_TURN;
            capture = 1'b1;
         end
         ST_TURN:  if (expire) nxt = ST_IDLE;
         ST_WOFF: if (expire) begin
            nxt  = ST_WDRV;
            load = 1'b1;
            len  = L_WDRV;
         end
         ST_WDRV: if (expire) begin
            nxt  = ST_WHOLD;
            load = 1'b1;
            len  = L_HOLD;
         end
         ST_WHOLD: if (expire) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   assign stb_d = decode_state(nxt, cur_we, WRITE_OE_LOW);

   // state, captured request and registered strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         op_we      <= 1'b0;
         op_be      <= '0;
         ram_addr   <= '0;
         ram_dq_o   <= '0;
         ram_ce1_n  <= 1'b1;
         ram_ce2    <= 1'b0;
         ram_we_n   <= 1'b1;
         ram_oe_n   <= 1'b1;
         ram_lane_n <= '1;
         ram_dq_oe  <= 1'b0;
      end else begin
         state <= nxt;
         if (accept) begin
            op_we    <= we;
            op_be    <= be;
            ram_addr <= addr;
            if (we) ram_dq_o <= wdata;
         end
         ram_ce1_n  <= !stb_d.sel;
         ram_ce2    <= stb_d.sel;
         ram_we_n   <= !stb_d.wr_low;
         ram_oe_n   <= !stb_d.rd_en;
         ram_lane_n <= stb_d.lanes_on ? ~cur_be : '1;
         ram_dq_oe  <= stb_d.drive;
      end
   end
endmodule

// File: rtl/sram_timing_ctrl_chk.sv
`timescale 1ns/100ps
module sram_timing_ctrl_chk #(
   parameter int AW        = 18,
   parameter int LANES     = 2,
   parameter int PWRUP_CYC = 100000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic             ready,
   input logic             rvalid,
   input logic [AW-1:0]    ram_addr,
   input logic             ram_ce1_n,
   input logic             ram_ce2,
   input logic             ram_we_n,
   input logic             ram_oe_n,
   input logic [LANES-1:0] ram_lane_n,
   input logic             ram_dq_oe
);
   logic [31:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= '0;
      else if (since_rst < 32'(PWRUP_CYC))
         since_rst <= since_rst + 1'b1;
   end

   assert_lockout_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ready || !ram_ce1_n) |-> (since_rst >= 32'(PWRUP_CYC)));

   assert_ce_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_ce1_n == !ram_ce2);

   assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ram_ce1_n && !ram_ce2));

   assert_rvalid_after_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> ($past(!ram_oe_n) && $past(!ram_ce1_n)));

   assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

   assert_we_end_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ram_we_n) && !ram_ce1_n) |->
         (ram_dq_oe && $stable(ram_addr) && $stable(ram_lane_n)));

   assert_we_inside_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> !ram_ce1_n);

   assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe |-> !$past(!ram_ce1_n && !ram_oe_n && ram_we_n));

   assert_wait_turnoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> !ram_dq_oe);

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> (!ready && !ram_ce1_n));
endmodule

bind sram_timing_ctrl sram_timing_ctrl_chk #(
   .AW(AW), .LANES(LANES), .PWRUP_CYC(PWRUP_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .rvalid(rvalid),
   .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2),
   .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_lane_n(ram_lane_n),
   .ram_dq_oe(ram_dq_oe)
);

// File: tb/sram_timing_ctrl_test.sv
`timescale 1ns/100ps
module sram_timing_ctrl_test;
   localparam int AW     = 4;
   localparam int LANES  = 2;
   localparam int PWRUP  = 40;
   localparam int TS     = 1;
   localparam int TRD    = 2;
   localparam int TTURN  = 1;
   localparam int TOFF   = 1;
   localparam int TWDRV  = 1;
   localparam int THOLD  = 1;
   localparam int RD_TOT = TS + TRD + TTURN;
   localparam int WR_TOT = TS + TOFF + TWDRV + THOLD;
   localparam int DEPTH  = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [1:0]  be = '0;
   logic ready, rvalid;
   logic [15:0] rdata;
   logic [AW-1:0] ram_addr;
   logic ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe;
   logic [1:0]  ram_lane_n;
   logic [15:0] ram_dq_o, ram_dq_i;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   sram_timing_ctrl #(
      .AW(AW), .LANES(LANES), .PWRUP_CYC(PWRUP), .T_SETUP(TS), .T_RD(TRD),
      .T_TURN(TTURN), .T_OFF(TOFF), .T_WDRV(TWDRV), .T_HOLD(THOLD),
      .WRITE_OE_LOW(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .be(be), .ready(ready), .rdata(rdata), .rvalid(rvalid), .ram_addr(ram_addr),
      .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2), .ram_we_n(ram_we_n),
      .ram_oe_n(ram_oe_n), .ram_lane_n(ram_lane_n), .ram_dq_o(ram_dq_o),
      .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
   );

   // ---------------- behavioural RAM model with rule counters ----------------
   logic [15:0] mem     [DEPTH];
   logic [15:0] exp_mem [DEPTH];
   int v_ce = 0, v_cont = 0, v_off = 0, v_term = 0, v_pulse = 0, v_addr = 0;
   int we_low = 0;
   logic p_sel = 1'b0, p_drv = 1'b0, p_oe = 1'b0, p_we_n = 1'b1;
   logic [AW-1:0] p_addr = '0;

   function automatic logic [15:0] init_word(int i);
      return 16'(i * 16'h0123) ^ 16'h5A00;
   endfunction

   wire sel     = !ram_ce1_n && ram_ce2;
   wire ram_drv = sel && !ram_oe_n && ram_we_n;

   always_comb begin
      for (int i = 0; i < 2; i++)
         ram_dq_i[8*i +: 8] = (ram_drv && !ram_lane_n[i]) ? mem[ram_addr][8*i +: 8] : 8'hA5;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_ce1_n != !ram_ce2) v_ce++;
         if (ready && sel) v_ce++;
         if (ram_dq_oe && (ram_drv || p_drv)) v_cont++;
         if (!ram_we_n) begin
            we_low++;
            if (we_low <= TOFF && ram_dq_oe) v_off++;
         end
         if (!p_we_n && ram_we_n && sel) begin
            if (!ram_dq_oe || !p_oe) v_term++;
            if (we_low < TOFF + TWDRV) v_pulse++;
            for (int i = 0; i < 2; i++)
               if (!ram_lane_n[i]) mem[ram_addr][8*i +: 8] = ram_dq_o[8*i +: 8];
         end
         if (ram_we_n) we_low = 0;
         if (sel && p_sel && ram_addr != p_addr) v_addr++;
         p_sel = sel; p_drv = ram_drv; p_oe = ram_dq_oe; p_we_n = ram_we_n; p_addr = ram_addr;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(bit ok, string rq, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] b);
      int k;
      req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
      @(negedge clk);
      req = 1'b0;
      k = 0;
      while (!ready && k < 50) begin @(negedge clk); k++; end
      chk(k == WR_TOT, "R8", "write busy cycles", k, WR_TOT);
      for (int i = 0; i < 2; i++)
         if (b[i]) exp_mem[a][8*i +: 8] = d[8*i +: 8];
   endtask

   task automatic do_read(logic [AW-1:0] a, logic [1:0] b, string rq);
      int k, kv;
      logic [15:0] got, expv;
      req = 1'b1; we = 1'b0; addr = a; be = b;
      @(negedge clk);
      req = 1'b0;
      k = 0; kv = -1; got = '0;
      if (rvalid) kv = 0;
      while (!ready && k < 50) begin
         @(negedge clk); k++;
         if (rvalid) begin kv = k; got = rdata; end
      end
      for (int i = 0; i < 2; i++)
         expv[8*i +: 8] = b[i] ? exp_mem[a][8*i +: 8] : 8'h00;
      chk(kv == TS + TRD, "R3", "rvalid edge", kv, TS + TRD);
      chk(got == expv, rq, "read data", got, expv);
      chk(k == RD_TOT, "R8", "read busy cycles", k, RD_TOT);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = init_word(i);
         exp_mem[i] = init_word(i);
      end
      repeat (3) @(negedge clk);
      chk(!ready && ram_ce1_n && !ram_ce2 && ram_we_n && ram_oe_n && !ram_dq_oe &&
          ram_lane_n == 2'b11, "R2", "reset levels", {ready, ram_ce1_n, ram_ce2}, 3'b010);
      rst_n = 1'b1;
      req = 1'b1; we = 1'b0; be = 2'b11;   // held high during lockout: must be ignored
      for (int k = 1; k <= PWRUP; k++) begin
         if (k == PWRUP) req = 1'b0;
         @(negedge clk);
         if (k < PWRUP)
            chk(!ready && ram_ce1_n, "R1", "lockout", {ready, ram_ce1_n}, 2'b01);
         else
            chk(ready, "R1", "ready after lockout", ready, 1);
      end
      // R5 sweep: lane pattern cycles through 00,01,10,11
      for (int a = 0; a < DEPTH; a++)
         do_write(AW'(a), 16'(a * 16'h1111 + 16'h0F0F), 2'(a));
      for (int a = 0; a < DEPTH; a++)
         do_read(AW'(a), 2'b11, "R5");
      // R3 lane masking on reads
      for (int a = 0; a < DEPTH; a++) begin
         do_read(AW'(a), 2'b01, "R3");
         do_read(AW'(a), 2'b10, "R3");
      end
      // R6/R7 back-to-back read then write then read
      do_read(AW'(3), 2'b11, "R6");
      do_write(AW'(3), 16'hC3D2, 2'b11);
      do_read(AW'(3), 2'b11, "R7");
      do_write(AW'(5), 16'hBEEF, 2'b10);
      do_read(AW'(5), 2'b11, "R4");
      @(negedge clk);
      chk(v_ce == 0,    "R2", "select rule breaches", v_ce, 0);
      chk(v_term == 0,  "R4", "write termination breaches", v_term, 0);
      chk(v_addr == 0,  "R4", "address change while selected", v_addr, 0);
      chk(v_pulse == 0, "R5", "short write pulses", v_pulse, 0);
      chk(v_cont == 0,  "R6", "bus contention", v_cont, 0);
      chk(v_off == 0,   "R7", "drive before output turn-off", v_off, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule